// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits between a CPU-side bus master and a memory or peripheral slave. It watches every request for addresses that fall inside one of two alias windows, one for an SRAM region and one for a peripheral region. Each 32-bit word in an alias window stands for one bit of one byte in the matching region. A CPU read of such a word returns 0 or 1. A CPU write of such a word changes that single bit, and no other bit of the byte changes. The write is done as a locked read-modify-write on the slave. Other requests go to the slave unchanged.

The master raises `m_req` and holds its request fields stable until `m_ready` pulses for one cycle. The slave side uses the same convention: the unit holds `s_req` and its fields stable until `s_ready` pulses. A single state machine (`bb_seq`) has six states:
- `ST_IDLE` accepts a request and takes one of four transitions:
  - to forward, for an address outside both windows;
  - to bit-read, for a CPU alias read;
  - to rmw-read, for a CPU alias write;
  - to fault, for a non-CPU alias access.
- `ST_FWD` passes the access through.
- `ST_BIT_RD` reads the target byte lane and returns the selected bit.
- `ST_RMW_RD` is the locked read phase. It moves to `ST_RMW_WR` on `s_ready`.
- `ST_RMW_WR` is the locked write-back.
- `ST_FAULT` answers with an error.

Every state except `ST_FAULT` returns to `ST_IDLE` on the final `s_ready`, and `ST_FAULT` returns after one cycle.

Top module: `bb_alias_unit`

## Requirements
- R1: For alias address A in a window with alias base AB and region base RB, the slave access goes to the word holding byte RB + A[24:5] − AB[24:5], with s_be one-hot on lane byte[1:0] (s_be bit i enables data bits 8i+7..8i). The bit index is A[4:2], and A[1:0] is ignored.
- R2: A CPU alias read returns m_rdata = 1 when the target bit is set and 0 when it is clear, with bits 31:1 zero.
- R3: A CPU alias write issues one read phase and then one write phase to the same word with the same one-hot s_be. The written lane carries the read byte with only the target bit replaced, and the byte is replicated on all four lanes of s_wdata.
- R4: The new bit value is m_wdata[0]. Bits 31:1 of m_wdata have no effect.
- R5: During an alias write, m_ready stays low until the write phase completes. It pulses in the cycle where the write phase's s_ready is high.
- R6: s_lock is high during both phases of an alias write and low for every other slave access.
- R7: An alias access with m_cpu low gets m_ready with m_err high, m_rdata zero, and no slave access. An alias write of this kind leaves memory unchanged.
- R8: An access outside both windows, from any master, reaches the slave with its address, s_we, s_be and s_wdata equal to the request. The slave data is returned unchanged on m_rdata.
- R9: The peripheral region (default region base 0x4000_0000, alias base 0x4200_0000) translates in the same way as the SRAM region (0x2000_0000 / 0x2200_0000). Each window spans 32 MB.
- R10: After reset, s_req, s_lock, m_ready and m_err are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request, held until m_ready |
| m_cpu | input | 1 | Request comes from the CPU |
| m_we | input | 1 | Master write |
| m_addr | input | 32 | Master byte address |
| m_be | input | 4 | Master byte enables |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | One-cycle completion pulse |
| m_err | output | 1 | Error response, valid with m_ready |
| m_rdata | output | 32 | Read data, valid with m_ready |
| s_req | output | 1 | Slave request, held until s_ready |
| s_lock | output | 1 | Slave must refuse other masters |
| s_we | output | 1 | Slave write |
| s_addr | output | 32 | Slave address |
| s_be | output | 4 | Slave byte enables |
| s_wdata | output | 32 | Slave write data |
| s_ready | input | 1 | Slave completion pulse |
| s_rdata | input | 32 | Slave read data |

## Verification
The bench covers four groups of cases.
- **Translation and bit read.** It reads all eight bits of one byte, the worked alias address 0x2200_6008, and the last bit of the last byte in the window. A wrong shift or lane choice returns neighbouring bits or touches the wrong word.
- **Alias writes.** It uses write data whose upper bits disagree with bit 0, so a design that takes the wrong data bit flips the bit the wrong way. It compares all four bytes of the word, so a design that writes the whole word corrupts its neighbours.
- **Per-clock monitor.** A monitor checks every clock that m_ready does not arrive after only the read phase and that the lock is present in both phases and absent elsewhere. It repeats this at slave latencies of 0 and 3.
- **Routing.** Non-CPU alias accesses must fault without reaching the slave. Addresses just outside a window must pass through untouched.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int LANE_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD,
        ST_BIT_RD,
        ST_RMW_RD,
        ST_RMW_WR,
        ST_FAULT
    } bb_state_e;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] word_addr;
        logic [LANE_W-1:0] lane;
        logic [2:0]        bit_idx;
    } bb_xlat_t;

    function automatic logic [7:0] bb_put_bit(input logic [7:0] b,
                                              input logic [2:0] idx,
                                              input logic       val);
        logic [7:0] r;
        r      = b;
        r[idx] = val;
        return r;
    endfunction

endpackage

// File: rtl/bb_decode.sv
module bb_decode
    import bb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h2200_0000,
    parameter int                SPAN_LOG2   = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output bb_xlat_t          xl
);
    localparam int ALIAS_LOG2 = SPAN_LOG2 + 5;

    logic [SPAN_LOG2-1:0] byte_off;
    logic [ADDR_W-1:0]    byte_addr;
    logic                 unused_low;

    assign unused_low   = &{1'b0, addr[1:0]};
    assign byte_off     = addr[ALIAS_LOG2-1:5];
    assign byte_addr    = REGION_BASE + {{(ADDR_W-SPAN_LOG2){1'b0}}, byte_off};

    assign xl.hit       = (addr[ADDR_W-1:ALIAS_LOG2] == ALIAS_BASE[ADDR_W-1:ALIAS_LOG2]);
    assign xl.word_addr = {byte_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    assign xl.lane      = byte_addr[LANE_W-1:0];
    assign xl.bit_idx   = addr[4:2];

endmodule

// File: rtl/bb_seq.sv
module bb_seq
    import bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              m_cpu,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [LANES-1:0]  m_be,
    input  logic [DATA_W-1:0] m_wdata,
    input  bb_xlat_t          xl,
    output logic              m_ready,
    output logic              m_err,
    output logic [DATA_W-1:0] m_rdata,
    output logic              s_req,
    output logic              s_lock,
    output logic              s_we,
    output logic [ADDR_W-1:0] s_addr,
    output logic [LANES-1:0]  s_be,
    output logic [DATA_W-1:0] s_wdata,
    input  logic              s_ready,
    input  logic [DATA_W-1:0] s_rdata
);
    bb_state_e         state, state_nx;
    logic [ADDR_W-1:0] cap_addr;
    logic [LANES-1:0]  cap_be;
    logic [DATA_W-1:0] cap_wdata;
    logic              cap_we;
    logic [LANE_W-1:0] cap_lane;
    logic [2:0]        cap_bit;
    logic              cap_newbit;
    logic [7:0]        rd_byte;
    logic [7:0]        lane_byte;
    logic [LANES-1:0]  lane_oh;

    assign lane_byte = s_rdata[{cap_lane, 3'b000} +: 8];
    assign lane_oh   = LANES'(1) << cap_lane;

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (m_req) begin
                    if (!xl.hit)     state_nx = ST_FWD;
                    else if (!m_cpu) state_nx = ST_FAULT;
                    else if (m_we)   state_nx = ST_RMW_RD;
                    else             state_nx = ST_BIT_RD;
                end
            end
            ST_FWD, ST_BIT_RD, ST_RMW_WR: if (s_ready) state_nx = ST_IDLE;
            ST_RMW_RD:                    if (s_ready) state_nx = ST_RMW_WR;
            ST_FAULT:                     state_nx = ST_IDLE;
            default:                      state_nx = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cap_addr   <= '0;
            cap_be     <= '0;
            cap_wdata  <= '0;
            cap_we     <= 1'b0;
            cap_lane   <= '0;
            cap_bit    <= '0;
            cap_newbit <= 1'b0;
            rd_byte    <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && m_req) begin
                cap_addr   <= xl.hit ? xl.word_addr : m_addr;
                cap_be     <= m_be;
                cap_wdata  <= m_wdata;
                cap_we     <= m_we;
                cap_lane   <= xl.lane;
                cap_bit    <= xl.bit_idx;
                cap_newbit <= m_wdata[0];
            end
            if (state == ST_RMW_RD && s_ready) rd_byte <= lane_byte;
        end
    end

    // outputs
    always_comb begin
        m_ready = 1'b0;
        m_err   = 1'b0;
        m_rdata = '0;
        s_req   = 1'b0;
        s_lock  = 1'b0;
        s_we    = 1'b0;
        s_addr  = cap_addr;
        s_be    = lane_oh;
        s_wdata = '0;
        unique case (state)
            ST_IDLE: ;
            ST_FWD: begin
                s_req   = 1'b1;
                s_we    = cap_we;
                s_be    = cap_be;
                s_wdata = cap_wdata;
                m_ready = s_ready;
                m_rdata = s_rdata;
            end
            ST_BIT_RD: begin
                s_req   = 1'b1;
                m_ready = s_ready;
                m_rdata = {{(DATA_W-1){1'b0}}, lane_byte[cap_bit]};
            end
            ST_RMW_RD: begin
                s_req  = 1'b1;
                s_lock = 1'b1;
            end
            ST_RMW_WR: begin
                s_req   = 1'b1;
                s_lock  = 1'b1;
                s_we    = 1'b1;
                s_wdata = {LANES{bb_put_bit(rd_byte, cap_bit, cap_newbit)}};
                m_ready = s_ready;
            end
            ST_FAULT: begin
                m_ready = 1'b1;
                m_err   = 1'b1;
            end
            default: ;
        endcase
    end

    // a completed locked read is followed by a locked write
    p_lock_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_lock && !s_we && s_ready) |=> (s_req && s_lock && s_we));

    // locked phases touch exactly one byte lane
    p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_lock) |-> ($countones(s_be) == 1));

    // no completion to the master while only the read phase is done
    p_no_early_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_lock && !s_we) |-> !m_ready);

    // an error response never coincides with a slave access
    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> (m_ready && !s_req));

    // the locked write goes to the word the locked read used
    p_same_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_lock && !s_we && s_ready) |=> (s_addr == $past(s_addr)));

endmodule

// File: rtl/bb_alias_unit.sv
module bb_alias_unit
    import bb_pkg::*;
#(
    parameter int                                  NUM_REGIONS  = 2,
    parameter int                                  SPAN_LOG2    = 20,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000},
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              m_cpu,
    input  logic              m_we,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [LANES-1:0]  m_be,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_ready,
    output logic              m_err,
    output logic [DATA_W-1:0] m_rdata,
    output logic              s_req,
    output logic              s_lock,
    output logic              s_we,
    output logic [ADDR_W-1:0] s_addr,
    output logic [LANES-1:0]  s_be,
    output logic [DATA_W-1:0] s_wdata,
    input  logic              s_ready,
    input  logic [DATA_W-1:0] s_rdata
);
    bb_xlat_t               xl_r [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] hit_vec;
    bb_xlat_t               xl_sel;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        bb_decode #(
            .REGION_BASE (REGION_BASES[g]),
            .ALIAS_BASE  (ALIAS_BASES[g]),
            .SPAN_LOG2   (SPAN_LOG2)
        ) u_dec (
            .addr (m_addr),
            .xl   (xl_r[g])
        );
        assign hit_vec[g] = xl_r[g].hit;
    end

    always_comb begin
        xl_sel = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (xl_r[i].hit) xl_sel = xl_r[i];
        end
    end

    bb_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .m_req   (m_req),
        .m_cpu   (m_cpu),
        .m_we    (m_we),
        .m_addr  (m_addr),
        .m_be    (m_be),
        .m_wdata (m_wdata),
        .xl      (xl_sel),
        .m_ready (m_ready),
        .m_err   (m_err),
        .m_rdata (m_rdata),
        .s_req   (s_req),
        .s_lock  (s_lock),
        .s_we    (s_we),
        .s_addr  (s_addr),
        .s_be    (s_be),
        .s_wdata (s_wdata),
        .s_ready (s_ready),
        .s_rdata (s_rdata)
    );

    // alias windows of different regions never overlap
    p_regions_disjoint_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: tb/bb_alias_unit_tb.sv
`timescale 1ns/1ps
module bb_alias_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0, m_cpu = 1'b0, m_we = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic [3:0]  m_be = '0;
    logic        m_ready, m_err;
    logic [31:0] m_rdata;
    logic        s_req, s_lock, s_we;
    logic [31:0] s_addr, s_wdata;
    logic [3:0]  s_be;
    logic        s_ready = 1'b0;
    logic [31:0] s_rdata = '0;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    bb_alias_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_cpu(m_cpu), .m_we(m_we), .m_addr(m_addr),
        .m_be(m_be), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata),
        .s_req(s_req), .s_lock(s_lock), .s_we(s_we), .s_addr(s_addr),
        .s_be(s_be), .s_wdata(s_wdata),
        .s_ready(s_ready), .s_rdata(s_rdata)
    );

    // ---------------- slave memory and reference memory ----------------
    logic [7:0] sl_mem  [logic [31:0]];
    logic [7:0] ref_mem [logic [31:0]];
    int         lat = 1;
    int         wcnt = 0;

    function automatic logic [7:0] pat(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    function automatic logic [7:0] sl_rd(logic [31:0] a);
        if (sl_mem.exists(a)) return sl_mem[a];
        return pat(a);
    endfunction
    function automatic logic [7:0] ref_rd(logic [31:0] a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return pat(a);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            s_ready <= 1'b0;
            wcnt    <= 0;
        end else if (s_ready) begin
            s_ready <= 1'b0;
            wcnt    <= 0;
        end else if (s_req) begin
            if (wcnt >= lat) begin
                logic [31:0] rd;
                for (int i = 0; i < 4; i++) begin
                    logic [31:0] ba;
                    ba = {s_addr[31:2], 2'(i)};
                    if (s_we && s_be[i]) sl_mem[ba] = s_wdata[8*i +: 8];
                    rd[8*i +: 8] = sl_rd(ba);
                end
                s_rdata <= rd;
                s_ready <= 1'b1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // ---------------- per-clock monitor ----------------
    bit          in_op = 0;
    int          exp_phases = 0;
    bit          exp_lock = 0;
    int          phases = 0;
    bit          lock_bad = 0;
    bit          early_ack = 0;
    logic [31:0] rd_addr, wr_addr, wr_data, pass_wdata;
    logic [3:0]  rd_be, wr_be, pass_be;
    logic        pass_we;

    always @(negedge clk) begin
        if (in_op) begin
            if (s_req && (s_lock != exp_lock)) lock_bad = 1;
            if (s_req && s_ready) begin
                phases++;
                pass_we    = s_we;
                pass_be    = s_be;
                pass_wdata = s_wdata;
                if (s_we) begin
                    wr_addr = s_addr; wr_be = s_be; wr_data = s_wdata;
                end else begin
                    rd_addr = s_addr; rd_be = s_be;
                end
            end
            if (m_ready && phases != exp_phases) early_ack = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [31:0] a, input logic we, input logic cpu,
                         input logic [31:0] wd, input logic [3:0] be,
                         input int ph, input bit lk,
                         output logic [31:0] rdata, output logic err);
        int guard = 0;
        @(negedge clk);
        exp_phases = ph; exp_lock = lk; phases = 0;
        lock_bad = 0; early_ack = 0;
        rd_addr = 'x; wr_addr = 'x; rd_be = 'x; wr_be = 'x;
        m_addr = a; m_we = we; m_cpu = cpu; m_wdata = wd; m_be = be;
        m_req = 1'b1; in_op = 1;
        forever begin
            @(negedge clk); #1;
            if (m_ready) break;
            guard++;
            if (guard > 200) break;
        end
        rdata = m_rdata; err = m_err;
        m_req = 1'b0; in_op = 0;
        chk(guard <= 200, "R5 op completes", 32'(guard), 32'd0);
        chk(phases == ph && !early_ack, "R5 slave phases before ack",
            32'(phases), 32'(ph));
        chk(!lock_bad, "R6 lock on locked phases only", 32'(lock_bad), 32'(lk));
    endtask

    function automatic logic [31:0] alias_of(logic [31:0] ab, logic [31:0] rb,
                                             logic [31:0] byte_a, int b);
        return ab + (byte_a - rb) * 32 + b * 4;
    endfunction

    task automatic bit_read(input logic [31:0] ab, input logic [31:0] rb,
                            input logic [31:0] ba, input int b, input string tag);
        logic [31:0] rd; logic er; logic [7:0] v;
        do_op(alias_of(ab, rb, ba, b), 1'b0, 1'b1, 32'hFFFF_FFFF, 4'hF, 1, 0, rd, er);
        v = ref_rd(ba);
        chk(rd == {31'd0, v[b]} && !er, {tag, " R2 bit value"}, rd, {31'd0, v[b]});
        chk(rd_addr == {ba[31:2], 2'b00} && rd_be == (4'b1 << ba[1:0]),
            {tag, " R1 slave word and lane"}, {rd_addr[31:4], rd_be},
            {ba[31:4], 4'b1 << ba[1:0]});
    endtask

    task automatic bit_write(input logic [31:0] ab, input logic [31:0] rb,
                             input logic [31:0] ba, input int b,
                             input logic [31:0] wd, input string tag);
        logic [31:0] rd, expw, actw; logic er; logic [7:0] v;
        do_op(alias_of(ab, rb, ba, b), 1'b1, 1'b1, wd, 4'h0, 2, 1, rd, er);
        v = ref_rd(ba); v[b] = wd[0]; ref_mem[ba] = v;
        chk(rd_addr == wr_addr && rd_be == wr_be && wr_be == (4'b1 << ba[1:0]),
            {tag, " R3 same word and lane"}, {wr_addr[31:4], wr_be},
            {ba[31:4], 4'b1 << ba[1:0]});
        chk(wr_data == {4{v}}, {tag, " R3 R4 written byte"}, wr_data, {4{v}});
        for (int i = 0; i < 4; i++) begin
            actw[8*i +: 8] = sl_rd({ba[31:2], 2'(i)});
            expw[8*i +: 8] = ref_rd({ba[31:2], 2'(i)});
        end
        chk(actw == expw && !er, {tag, " R3 R4 memory word"}, actw, expw);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] rd, expw, actw;
        logic er;

        repeat (3) @(negedge clk);
        chk(!s_req && !s_lock && !m_ready && !m_err, "R10 reset outputs",
            {28'd0, s_req, s_lock, m_ready, m_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!s_req && !s_lock && !m_ready && !m_err, "R10 idle after reset",
            {28'd0, s_req, s_lock, m_ready, m_err}, 32'd0);

        // worked example address
        do_op(32'h2200_6008, 1'b0, 1'b1, 32'h0, 4'hF, 1, 0, rd, er);
        chk(rd_addr == 32'h2000_0300 && rd_be == 4'b0001,
            "R1 0x22006008 maps to byte 0x20000300", rd_addr, 32'h2000_0300);
        chk(rd == {31'd0, pat(32'h2000_0300)[2]}, "R2 0x22006008 bit 2",
            rd, {31'd0, pat(32'h2000_0300)[2]});
        do_op(32'h2200_600B, 1'b0, 1'b1, 32'h0, 4'hF, 1, 0, rd, er);
        chk(rd_addr == 32'h2000_0300 && rd == {31'd0, pat(32'h2000_0300)[2]},
            "R1 low address bits ignored", rd, {31'd0, pat(32'h2000_0300)[2]});

        for (int b = 0; b < 8; b++)
            bit_read(32'h2200_0000, 32'h2000_0000, 32'h2000_0123, b, "sram bits");

        lat = 0;
        bit_write(32'h2200_0000, 32'h2000_0000, 32'h2000_0301, 5, 32'h0000_0001, "set lat0");
        bit_write(32'h2200_0000, 32'h2000_0000, 32'h2000_0301, 5, 32'hFFFF_FFFE, "clear wide R4");
        lat = 3;
        bit_write(32'h2200_0000, 32'h2000_0000, 32'h2000_0302, 0, 32'h8000_0000, "clear hi R4");
        bit_write(32'h2200_0000, 32'h2000_0000, 32'h2000_0302, 7, 32'h7FFF_FFFF, "set lat3");
        bit_read(32'h2200_0000, 32'h2000_0000, 32'h2000_0302, 7, "readback");
        lat = 1;

        // last bit of the last byte in the window
        bit_read (32'h2200_0000, 32'h2000_0000, 32'h200F_FFFF, 7, "edge");
        bit_write(32'h2200_0000, 32'h2000_0000, 32'h200F_FFFF, 7, 32'h0, "edge");

        // peripheral region
        bit_read (32'h4200_0000, 32'h4000_0000, 32'h4000_1234, 3, "R9 periph");
        bit_write(32'h4200_0000, 32'h4000_0000, 32'h4000_1234, 3,
                  {31'd0, ~pat(32'h4000_1234)[3]}, "R9 periph");

        // non-CPU alias access
        do_op(32'h2200_6008, 1'b0, 1'b0, 32'h0, 4'hF, 0, 0, rd, er);
        chk(er && rd == 32'd0, "R7 non-CPU alias read faults", {31'd0, er}, 32'd1);
        do_op(alias_of(32'h2200_0000, 32'h2000_0000, 32'h2000_0301, 1),
              1'b1, 1'b0, 32'h1, 4'hF, 0, 0, rd, er);
        chk(er, "R7 non-CPU alias write faults", {31'd0, er}, 32'd1);
        chk(sl_rd(32'h2000_0301) == ref_rd(32'h2000_0301),
            "R7 memory unchanged after fault", {24'd0, sl_rd(32'h2000_0301)},
            {24'd0, ref_rd(32'h2000_0301)});

        // pass-through
        do_op(32'h2000_0400, 1'b0, 1'b1, 32'h0, 4'hF, 1, 0, rd, er);
        for (int i = 0; i < 4; i++) expw[8*i +: 8] = ref_rd(32'h2000_0400 + i);
        chk(rd == expw && rd_addr == 32'h2000_0400 && rd_be == 4'hF && !er,
            "R8 pass read", rd, expw);
        do_op(32'h2000_0404, 1'b1, 1'b0, 32'hDEAD_BEEF, 4'b0110, 1, 0, rd, er);
        ref_mem[32'h2000_0405] = 8'hBE; ref_mem[32'h2000_0406] = 8'hAD;
        chk(wr_addr == 32'h2000_0404 && pass_be == 4'b0110 && pass_we &&
            pass_wdata == 32'hDEAD_BEEF && !er, "R8 non-CPU pass write fields",
            pass_wdata, 32'hDEAD_BEEF);
        for (int i = 0; i < 4; i++) begin
            actw[8*i +: 8] = sl_rd(32'h2000_0404 + i);
            expw[8*i +: 8] = ref_rd(32'h2000_0404 + i);
        end
        chk(actw == expw, "R8 pass write memory", actw, expw);
        do_op(32'h2400_0000, 1'b0, 1'b1, 32'h0, 4'b0001, 1, 0, rd, er);
        chk(rd_addr == 32'h2400_0000 && rd_be == 4'b0001 && !er,
            "R8 just above window passes", rd_addr, 32'h2400_0000);
        do_op(32'h21FF_FFFC, 1'b1, 1'b1, 32'h0000_0003, 4'b1000, 1, 0, rd, er);
        ref_mem[32'h21FF_FFFF] = 8'h00;
        chk(wr_addr == 32'h21FF_FFFC && wr_be == 4'b1000 && !er,
            "R8 just below window passes", wr_addr, 32'h21FF_FFFC);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule